// File: doc/BRIEF.md
# Quadrature Reference Divider Chain

This block divides a 10 MHz reference clock by 128 and drives two square waves in quadrature at 78.125 kHz. Each output is meant to feed its own low-pass filter. The two filters are identical, so the outputs become a sine and a cosine that an external converter can sample. The chain has three stages. A synchronous binary prescaler divides by 32. A retiming flip-flop re-registers the prescaler's top bit on the reference clock. A 2-bit twisted-ring counter then advances once for each rising edge of that retimed signal, which gives the final divide by 4. The two quadrature outputs come straight from the two ring flip-flops, with no logic after them.

The block also takes a pulse-per-second input. It synchronises that input into the reference domain. On each rising edge it records the 7-bit phase state of the whole chain and raises a one-cycle strobe. Software or a later stage can then turn the sampled filter voltages and this coarse phase into a fine time offset.

Top module: `qdiv_quad_ref`

## Requirements
- R1: While the synchronous active-high reset is asserted, and on the first cycle after it, both quadrature outputs, the captured phase and the strobe are all low.
- R2: The prescaler is a free-running 5-bit counter. It adds one on every reference edge and wraps from 31 to 0. It appears as bits [4:0] of the captured phase.
- R3: The ring state, read as {q, i}, steps through 00, 01, 11, 10 and then back to 00. Each step changes exactly one output: i takes the inverse of the old q, and q takes the old i.
- R4: Each output is high for 64 reference cycles and low for 64, so the period is 128 cycles.
- R5: The two outputs never change in the same cycle. Each q transition comes 32 reference cycles after the i transition before it (i leads by 90 degrees).
- R6: Counting edges from reset release, the ring advances on edge 17 and then on every 32nd edge. Each advance is the edge that takes the prescaler count to 17.
- R7: The PPS input goes through two synchroniser flops. If it rises between edges n and n+1, the strobe is high for exactly one cycle after edge n+3. The captured value then holds {ring state after edge n+2, prescaler count after edge n+2}, with the ring state in bits [6:5] ({q,i}) and the count in bits [4:0].
- R8: A PPS input that stays high, stays low, or falls does not raise the strobe, and the captured value does not change.
- R9: A reset in the middle of a run restarts the chain, so the first ring advance again falls on edge 17 after release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | 10 MHz reference clock |
| rst | input | 1 | Synchronous reset, active high |
| pps_in | input | 1 | Asynchronous pulse-per-second input |
| quad_i_o | output | 1 | In-phase output, ring bit 0 |
| quad_q_o | output | 1 | Quadrature output, ring bit 1 |
| phase_o | output | 7 | Captured {ring, prescaler} state |
| phase_vld_o | output | 1 | One-cycle strobe for a new capture |

## Verification
The capture of a PPS edge and a ring advance can happen on the same reference edge. The bench provokes this by placing the PPS rise so that the capture edge is an advance edge, which is the one where the prescaler reaches 17. On that edge the captured ring field must still show the state before the advance, while the outputs already show the state after it. Both values are worked out from the edge count since reset.

// File: rtl/qdiv_pkg.sv
package qdiv_pkg;

    typedef enum logic [1:0] {
        RING_00 = 2'b00,
        RING_01 = 2'b01,
        RING_11 = 2'b11,
        RING_10 = 2'b10
    } ring_state_e;

    function automatic ring_state_e ring_next(input ring_state_e cur);
        logic [1:0] b;
        b = cur;
        return ring_state_e'({b[0], ~b[1]});
    endfunction

endpackage

// File: rtl/qdiv_prescaler.sv
module qdiv_prescaler #(
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst,
    output logic [CNT_W-1:0] cnt_o,
    output logic             tap_o
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } presc_st_t;

    presc_st_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.cnt = st_q.cnt + CNT_W'(1);
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign cnt_o = st_q.cnt;
    assign tap_o = st_q.cnt[CNT_W-1];
endmodule

// File: rtl/qdiv_retime_ring.sv
module qdiv_retime_ring
    import qdiv_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        tap_i,
    output ring_state_e ring_o
);
    typedef struct packed {
        logic        tap;
        ring_state_e ring;
    } ring_st_t;

    ring_st_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.tap = tap_i;
        if (tap_i && !st_q.tap) begin
            st_d.ring = ring_next(st_q.ring);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '{tap: 1'b0, ring: RING_00};
        else     st_q <= st_d;
    end

    assign ring_o = st_q.ring;
endmodule

// File: rtl/qdiv_pps_capture.sv
module qdiv_pps_capture #(
    parameter int SYNC_N = 2,
    parameter int CAP_W  = 7
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             pps_i,
    input  logic [CAP_W-1:0] snap_i,
    output logic [CAP_W-1:0] cap_o,
    output logic             vld_o
);
    localparam int SH_W = SYNC_N + 1;

    typedef struct packed {
        logic [SH_W-1:0]  sh;
        logic [CAP_W-1:0] cap;
        logic             vld;
    } cap_st_t;

    cap_st_t st_d, st_q;
    logic    rise;

    assign rise = st_q.sh[SYNC_N-1] & ~st_q.sh[SYNC_N];

    always_comb begin
        st_d     = st_q;
        st_d.sh  = {st_q.sh[SH_W-2:0], pps_i};
        st_d.vld = rise;
        if (rise) begin
            st_d.cap = snap_i;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign cap_o = st_q.cap;
    assign vld_o = st_q.vld;
endmodule

// File: rtl/qdiv_quad_ref.sv
module qdiv_quad_ref
    import qdiv_pkg::*;
#(
    parameter int PRESC_W = 5,
    parameter int SYNC_N  = 2,
    parameter int PHASE_W = PRESC_W + 2
) (
    input  logic               clk_ref,
    input  logic               rst,
    input  logic               pps_in,
    output logic               quad_i_o,
    output logic               quad_q_o,
    output logic [PHASE_W-1:0] phase_o,
    output logic               phase_vld_o
);
    logic [PRESC_W-1:0] presc_cnt;
    logic               presc_tap;
    ring_state_e        ring;

    qdiv_prescaler #(.CNT_W(PRESC_W)) presc_u (
        .clk   (clk_ref),
        .rst   (rst),
        .cnt_o (presc_cnt),
        .tap_o (presc_tap)
    );

    qdiv_retime_ring ring_u (
        .clk    (clk_ref),
        .rst    (rst),
        .tap_i  (presc_tap),
        .ring_o (ring)
    );

    qdiv_pps_capture #(.SYNC_N(SYNC_N), .CAP_W(PHASE_W)) cap_u (
        .clk    (clk_ref),
        .rst    (rst),
        .pps_i  (pps_in),
        .snap_i ({ring, presc_cnt}),
        .cap_o  (phase_o),
        .vld_o  (phase_vld_o)
    );

    assign quad_i_o = ring[0];
    assign quad_q_o = ring[1];
endmodule

// File: rtl/qdiv_quad_ref_chk.sv
module qdiv_quad_ref_chk #(
    parameter int PRESC_W = 5,
    parameter int PHASE_W = PRESC_W + 2
) (
    input logic               clk_ref,
    input logic               rst,
    input logic               quad_i_o,
    input logic               quad_q_o,
    input logic [PRESC_W-1:0] presc_cnt,
    input logic [PHASE_W-1:0] phase_o,
    input logic               phase_vld_o
);
    localparam logic [PRESC_W-1:0] ADV_SLOT = PRESC_W'((1 << (PRESC_W - 1)) + 1);

    a_r2_count_step: assert property (@(posedge clk_ref) disable iff (rst)
        !$past(rst) |-> presc_cnt == $past(presc_cnt) + PRESC_W'(1));

    a_r3_i_takes_not_q: assert property (@(posedge clk_ref) disable iff (rst)
        (!$past(rst) && quad_i_o != $past(quad_i_o)) |-> quad_i_o == !$past(quad_q_o));

    a_r3_q_takes_i: assert property (@(posedge clk_ref) disable iff (rst)
        (!$past(rst) && quad_q_o != $past(quad_q_o)) |-> quad_q_o == $past(quad_i_o));

    a_r5_no_dual_toggle: assert property (@(posedge clk_ref) disable iff (rst)
        !$past(rst) |-> !(quad_i_o != $past(quad_i_o) && quad_q_o != $past(quad_q_o)));

    a_r6_advance_slot: assert property (@(posedge clk_ref) disable iff (rst)
        (!$past(rst) && (quad_i_o != $past(quad_i_o) || quad_q_o != $past(quad_q_o)))
        |-> presc_cnt == ADV_SLOT);

    a_r7_single_strobe: assert property (@(posedge clk_ref) disable iff (rst)
        phase_vld_o |=> !phase_vld_o);

    a_r8_capture_on_strobe: assert property (@(posedge clk_ref) disable iff (rst)
        (!$past(rst) && phase_o != $past(phase_o)) |-> phase_vld_o);
endmodule

bind qdiv_quad_ref qdiv_quad_ref_chk #(.PRESC_W(PRESC_W), .PHASE_W(PHASE_W)) chk_u (
    .clk_ref     (clk_ref),
    .rst         (rst),
    .quad_i_o    (quad_i_o),
    .quad_q_o    (quad_q_o),
    .presc_cnt   (presc_cnt),
    .phase_o     (phase_o),
    .phase_vld_o (phase_vld_o)
);

// File: tb/qdiv_quad_ref_tb_top.sv
module qdiv_quad_ref_tb_top;
    localparam int CLK_PERIOD = 100;

    logic       clk_ref = 1'b0;
    logic       rst     = 1'b1;
    logic       pps_in  = 1'b0;
    logic       quad_i_o, quad_q_o, phase_vld_o;
    logic [6:0] phase_o;

    int errors = 0;
    int checks = 0;
    int edges  = 0;

    always #(CLK_PERIOD / 2) clk_ref = ~clk_ref;

    qdiv_quad_ref dut_i (
        .clk_ref     (clk_ref),
        .rst         (rst),
        .pps_in      (pps_in),
        .quad_i_o    (quad_i_o),
        .quad_q_o    (quad_q_o),
        .phase_o     (phase_o),
        .phase_vld_o (phase_vld_o)
    );

    function automatic logic [1:0] exp_ring(input int n);
        int adv;
        adv = (n >= 17) ? ((n - 17) / 32 + 1) : 0;
        case (adv % 4)
            0:       return 2'b00;
            1:       return 2'b01;
            2:       return 2'b11;
            default: return 2'b10;
        endcase
    endfunction

    function automatic logic [4:0] exp_cnt(input int n);
        return 5'(n % 32);
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk_ref);
        edges++;
        @(negedge clk_ref);
    endtask

    task automatic do_reset();
        rst    = 1'b1;
        pps_in = 1'b0;
        repeat (3) tick();
        rst   = 1'b0;
        edges = 0;
    endtask

    task automatic run_to(input int n);
        while (edges < n) tick();
    endtask

    task automatic t_reset();
        @(negedge clk_ref);
        do_reset();
        check({quad_q_o, quad_i_o} == 2'b00, "R1 outputs", {quad_q_o, quad_i_o}, 0);
        check(phase_o == 7'd0 && !phase_vld_o, "R1 capture", {phase_vld_o, phase_o}, 0);
        tick();
        check({quad_q_o, quad_i_o} == 2'b00 && !phase_vld_o, "R1 after release",
              {phase_vld_o, quad_q_o, quad_i_o}, 0);
    endtask

    task automatic t_waveform();
        int first_i = -1, last_i = -1, bad_iv = 0, bad_seq = 0, bad_q = 0, dual = 0;
        logic pi, pq;
        do_reset();
        pi = quad_i_o; pq = quad_q_o;
        for (int k = 0; k < 600; k++) begin
            tick();
            if ({quad_q_o, quad_i_o} != exp_ring(edges)) bad_seq++;
            if (quad_i_o != pi && quad_q_o != pq) dual++;
            if (quad_i_o != pi) begin
                if (first_i < 0) first_i = edges;
                else if (edges - last_i != 64) bad_iv++;
                last_i = edges;
            end
            if (quad_q_o != pq && (last_i < 0 || edges - last_i != 32)) bad_q++;
            pi = quad_i_o; pq = quad_q_o;
        end
        check(first_i == 17, "R6 first advance edge", first_i, 17);
        check(bad_seq == 0, "R3 ring sequence", bad_seq, 0);
        check(bad_iv == 0, "R4 half period 64", bad_iv, 0);
        check(bad_q == 0, "R5 q lags i by 32", bad_q, 0);
        check(dual == 0, "R5 no simultaneous toggle", dual, 0);
    endtask

    task automatic t_capture(input int n0, input string tag);
        logic [6:0] exp;
        run_to(n0);
        pps_in = 1'b1;
        tick(); tick();
        check(!phase_vld_o, {tag, " no early strobe"}, phase_vld_o, 0);
        tick();
        exp = {exp_ring(n0 + 2), exp_cnt(n0 + 2)};
        check(phase_vld_o, {tag, " strobe"}, phase_vld_o, 1);
        check(phase_o == exp, {tag, " captured phase"}, phase_o, exp);
        tick();
        check(!phase_vld_o, {tag, " strobe one cycle"}, phase_vld_o, 0);
        pps_in = 1'b0;
        repeat (4) tick();
        check(phase_o == exp && !phase_vld_o, "R8 fall ignored", phase_o, exp);
    endtask

    task automatic t_coincide();
        int n0;
        logic [6:0] exp;
        n0 = 174;
        run_to(n0);
        pps_in = 1'b1;
        repeat (3) tick();
        exp = {exp_ring(n0 + 2), exp_cnt(n0 + 2)};
        check(phase_vld_o && phase_o == exp, "R7 capture at advance edge", phase_o, exp);
        check({quad_q_o, quad_i_o} == exp_ring(n0 + 3), "R6 outputs advanced same edge",
              {quad_q_o, quad_i_o}, exp_ring(n0 + 3));
        pps_in = 1'b0;
        tick();
    endtask

    task automatic t_hold();
        int strobes = 0;
        logic [6:0] held;
        held = phase_o;
        pps_in = 1'b1;
        repeat (3) tick();
        held = phase_o;
        for (int k = 0; k < 40; k++) begin
            tick();
            if (phase_vld_o) strobes++;
        end
        check(strobes == 0, "R8 steady high no strobe", strobes, 0);
        check(phase_o == held, "R8 capture held", phase_o, held);
        pps_in = 1'b0;
        for (int k = 0; k < 40; k++) begin
            tick();
            if (phase_vld_o) strobes++;
        end
        check(strobes == 0, "R8 steady low no strobe", strobes, 0);
    endtask

    task automatic t_midreset();
        int first = -1;
        logic pi;
        run_to(edges + 37);
        do_reset();
        check({quad_q_o, quad_i_o} == 2'b00 && phase_o == 7'd0, "R9 cleared",
              {quad_q_o, quad_i_o, phase_o}, 0);
        pi = quad_i_o;
        for (int k = 0; k < 40; k++) begin
            tick();
            if (quad_i_o != pi && first < 0) first = edges;
            pi = quad_i_o;
        end
        check(first == 17, "R9 restart advance edge", first, 17);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        t_reset();
        t_waveform();
        do_reset();
        t_capture(5, "R7 early");
        t_capture(40, "R2 wrap region");
        t_capture(100, "R7 mid");
        t_coincide();
        t_hold();
        t_capture(300, "R2 late");
        t_midreset();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule